// File: doc/BRIEF.md
# Compressed Page Line Locator

This block turns a request for one 64-byte cache line of a 4KB virtual page into a physical DRAM access. A compressed page stores every line in the same fixed compressed size, so the line's position is its index scaled by that size. The compressed data area is followed by a 64-byte metadata block and then by full-size exception slots. The block takes the page's frame address, the page-entry fields and the page's metadata, which some caller has already fetched. It returns the byte address to read, how many bytes to move, and what kind of line it is.

A request is accepted on any cycle that `req_valid` is high, and the answer appears one clock later. Requests may arrive back to back. The control is a small state machine whose state is the kind of the line now being answered. The states are `ST_IDLE`, `ST_ZERO`, `ST_COMP`, `ST_EXC` and `ST_RAW`. On every clock the next state is chosen from the new request:
- no request goes to `ST_IDLE`;
- an uncompressed page goes to `ST_RAW`;
- a line whose zero bit is set goes to `ST_ZERO`;
- a line whose exception bit is set goes to `ST_EXC`;
- any other line of a compressed page goes to `ST_COMP`.

Any state can move to any state.

Top module: `lcp_line_locator`

## Requirements
- R1: A response (`rsp_valid` high) appears exactly one clock after each cycle with `req_valid` high, and in no other cycle. While `rsp_valid` is low, `rsp_addr`, `rsp_len` and `rsp_kind` are all zero, including right after reset.
- R2: When `pte_comp` is 0, the response is as follows, and the metadata, type, size class and base offset have no effect:
  - kind is 2'b11;
  - length is 64;
  - address is `page_base + 64*line_idx`.
- R3: The per-line compressed size S is derived from `pte_type`. Types 0, 1, 2 and 3 give 8, 16, 32 and 64 bytes. Types 4 to 7 give 64 bytes.
- R4: The base offset is in 512-byte units and is aligned down to the size class. Size class c (0..3 meaning 512B, 1KB, 2KB, 4KB) clears the low c bits of `pte_base_off`, so class 3 always gives offset 0. The compressed frame start F is `page_base + 512*aligned_offset`.
- R5: A compressed line with neither flag set reports kind 2'b01, length S and address `F + line_idx*S`.
- R6: The metadata layout is fixed:
  - bit `meta[64+i]` marks line i as all-zero;
  - bit `meta[i]` marks line i as an exception;
  - `meta[128+6*i +: 6]` is line i's exception slot k.
- R7: A zero line of a compressed page reports kind 2'b00 and length 0, at address `F + line_idx*S`. The zero bit wins over the exception bit.
- R8: An exception line with its zero bit clear reports kind 2'b10, length 64 and address `F + 64*S + 64 + 64*k`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| page_base | input | 40 | Byte address of the physical frame |
| pte_comp | input | 1 | Page is stored compressed |
| pte_type | input | 3 | Compression type, selects line size |
| pte_size | input | 2 | Physical size class |
| pte_base_off | input | 3 | Start of compressed page in 512B units |
| line_idx | input | 6 | Line index in the 4KB page |
| meta | input | 512 | The page's 64-byte metadata block |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | 40 | DRAM byte address |
| rsp_len | output | 7 | Bytes to transfer (0..64) |
| rsp_kind | output | 2 | 00 zero, 01 compressed, 10 exception, 11 uncompressed |

## Verification
A wrong state register shows in the very next response as a wrong kind code and a length that does not match it. That happens even when the address is right. A wrong slot pick or wrong scaling shifts `rsp_addr` by a multiple of the line size, or of 64, on the first request that touches that line, type or slot. A wrong base alignment shows as an address error that depends only on the size class. The sweep covers the following:
- every line;
- every type;
- four size/offset pairs;
- two metadata patterns that mix zero, exception and plain lines with distinct slot numbers.

So each such fault surfaces within one response of the stimulus that exposes it.

// File: rtl/lcp_pkg.sv
package lcp_pkg;
    localparam int LINE_BYTES = 64;
    localparam int NLINES     = 64;
    localparam int IDX_W      = $clog2(NLINES);
    localparam int SLOT_W     = 6;
    localparam int META_W     = LINE_BYTES * 8;
    localparam int LEN_W      = $clog2(LINE_BYTES) + 1;

    typedef enum logic [1:0] {
        KIND_ZERO = 2'b00,
        KIND_COMP = 2'b01,
        KIND_EXC  = 2'b10,
        KIND_RAW  = 2'b11
    } line_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ZERO,
        ST_COMP,
        ST_EXC,
        ST_RAW
    } loc_state_e;
endpackage

// File: rtl/lcp_meta_decode.sv
module lcp_meta_decode
    import lcp_pkg::*;
(
    input  logic [META_W-1:0] meta,
    input  logic [IDX_W-1:0]  line_idx,
    output logic              is_zero,
    output logic              is_exc,
    output logic [SLOT_W-1:0] slot
);
    localparam int EXC_LO  = 0;
    localparam int ZERO_LO = NLINES;
    localparam int SLOT_LO = 2 * NLINES;

    logic [NLINES-1:0] exc_bits;
    logic [NLINES-1:0] zero_bits;
    logic [SLOT_W-1:0] slot_tab [NLINES];

    assign exc_bits  = meta[EXC_LO  +: NLINES];
    assign zero_bits = meta[ZERO_LO +: NLINES];

    for (genvar gi = 0; gi < NLINES; gi++) begin : g_slot
        assign slot_tab[gi] = meta[SLOT_LO + SLOT_W*gi +: SLOT_W];
    end

    assign is_zero = zero_bits[line_idx];
    assign is_exc  = exc_bits[line_idx];
    assign slot    = slot_tab[line_idx];
endmodule

// File: rtl/lcp_addr_calc.sv
module lcp_addr_calc
    import lcp_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic [ADDR_W-1:0] page_base,
    input  logic [2:0]        pte_type,
    input  logic [1:0]        pte_size,
    input  logic [2:0]        pte_base_off,
    input  logic [IDX_W-1:0]  line_idx,
    input  logic [SLOT_W-1:0] slot,
    output logic [ADDR_W-1:0] comp_addr,
    output logic [ADDR_W-1:0] exc_addr,
    output logic [ADDR_W-1:0] raw_addr,
    output logic [LEN_W-1:0]  comp_len
);
    localparam int UNIT_SH = 9;
    localparam int LINE_SH = $clog2(LINE_BYTES);

    logic [2:0]        size_sh;
    logic [3:0]        align_mask;
    logic [2:0]        off_eff;
    logic [ADDR_W-1:0] frame;
    logic [ADDR_W-1:0] data_span;

    always_comb begin
        size_sh    = pte_type[2] ? 3'd6 : (3'd3 + {1'b0, pte_type[1:0]});
        align_mask = (4'd1 << pte_size) - 4'd1;
        off_eff    = pte_base_off & ~align_mask[2:0];
        frame      = page_base + (ADDR_W'(off_eff) << UNIT_SH);
        data_span  = ADDR_W'(NLINES) << size_sh;
        comp_addr  = frame + (ADDR_W'(line_idx) << size_sh);
        exc_addr   = frame + data_span + ADDR_W'(LINE_BYTES)
                   + (ADDR_W'(slot) << LINE_SH);
        raw_addr   = page_base + (ADDR_W'(line_idx) << LINE_SH);
        comp_len   = LEN_W'(1) << size_sh;
    end
endmodule

// File: rtl/lcp_line_locator.sv
module lcp_line_locator
    import lcp_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] page_base,
    input  logic              pte_comp,
    input  logic [2:0]        pte_type,
    input  logic [1:0]        pte_size,
    input  logic [2:0]        pte_base_off,
    input  logic [5:0]        line_idx,
    input  logic [511:0]      meta,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [6:0]        rsp_len,
    output logic [1:0]        rsp_kind
);
    loc_state_e        state_q, state_d;
    logic              is_zero, is_exc;
    logic [SLOT_W-1:0] slot;
    logic [ADDR_W-1:0] comp_addr, exc_addr, raw_addr;
    logic [LEN_W-1:0]  comp_len;
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [LEN_W-1:0]  clen_q;

    lcp_meta_decode u_meta (
        .meta     (meta),
        .line_idx (line_idx),
        .is_zero  (is_zero),
        .is_exc   (is_exc),
        .slot     (slot)
    );

    lcp_addr_calc #(.ADDR_W(ADDR_W)) u_calc (
        .page_base    (page_base),
        .pte_type     (pte_type),
        .pte_size     (pte_size),
        .pte_base_off (pte_base_off),
        .line_idx     (line_idx),
        .slot         (slot),
        .comp_addr    (comp_addr),
        .exc_addr     (exc_addr),
        .raw_addr     (raw_addr),
        .comp_len     (comp_len)
    );

    // next-state and address select
    always_comb begin
        state_d = ST_IDLE;
        addr_d  = '0;
        if (req_valid) begin
            if (!pte_comp) begin
                state_d = ST_RAW;
                addr_d  = raw_addr;
            end else if (is_zero) begin
                state_d = ST_ZERO;
                addr_d  = comp_addr;
            end else if (is_exc) begin
                state_d = ST_EXC;
                addr_d  = exc_addr;
            end else begin
                state_d = ST_COMP;
                addr_d  = comp_addr;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            clen_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            clen_q  <= comp_len;
        end
    end

    // outputs from state
    always_comb begin
        rsp_valid = 1'b1;
        rsp_addr  = addr_q;
        rsp_len   = '0;
        rsp_kind  = KIND_ZERO;
        unique case (state_q)
            ST_IDLE: begin
                rsp_valid = 1'b0;
                rsp_addr  = '0;
            end
            ST_ZERO: begin
                rsp_kind = KIND_ZERO;
                rsp_len  = '0;
            end
            ST_COMP: begin
                rsp_kind = KIND_COMP;
                rsp_len  = clen_q;
            end
            ST_EXC: begin
                rsp_kind = KIND_EXC;
                rsp_len  = 7'(LINE_BYTES);
            end
            ST_RAW: begin
                rsp_kind = KIND_RAW;
                rsp_len  = 7'(LINE_BYTES);
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_addr  = '0;
            end
        endcase
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R1
    AST_RAW_PAGE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pte_comp) |=> (rsp_kind == 2'b11 && rsp_len == 7'd64)); // R2
    AST_ZERO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pte_comp && meta[64 + line_idx]) |=> (rsp_kind == 2'b00 && rsp_len == 7'd0)); // R7
    AST_EXC_FULL_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pte_comp && !meta[64 + line_idx] && meta[line_idx]) |=> (rsp_kind == 2'b10 && rsp_len == 7'd64)); // R8
    AST_COMP_LEN_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == 2'b01) |-> ($countones(rsp_len) == 1 && rsp_len >= 7'd8)); // R3
endmodule

// File: tb/lcp_line_locator_tb.sv
module lcp_line_locator_tb;
    localparam int AW = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] page_base = '0;
    logic          pte_comp = 1'b0;
    logic [2:0]    pte_type = '0;
    logic [1:0]    pte_size = '0;
    logic [2:0]    pte_base_off = '0;
    logic [5:0]    line_idx = '0;
    logic [511:0]  meta = '0;
    logic          rsp_valid;
    logic [AW-1:0] rsp_addr;
    logic [6:0]    rsp_len;
    logic [1:0]    rsp_kind;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    lcp_line_locator #(.ADDR_W(AW)) u_dut (
        .clk, .rst_n, .req_valid, .page_base, .pte_comp, .pte_type,
        .pte_size, .pte_base_off, .line_idx, .meta,
        .rsp_valid, .rsp_addr, .rsp_len, .rsp_kind
    );

    task automatic check(input string req, input logic [AW-1:0] a, input logic [6:0] l,
                         input logic [1:0] k, input logic v,
                         input logic [AW-1:0] ea, input logic [6:0] el,
                         input logic [1:0] ek, input logic ev);
        n_checks++;
        if (a !== ea || l !== el || k !== ek || v !== ev) begin
            n_errors++;
            $display("FAIL %s: got v=%0b addr=%h len=%0d kind=%0d, exp v=%0b addr=%h len=%0d kind=%0d",
                     req, v, a, l, k, ev, ea, el, ek);
        end
    endtask

    function automatic logic [511:0] make_meta(input int pat);
        logic [511:0] m = '0;
        for (int i = 0; i < 64; i++) begin
            if (pat == 0) begin
                m[64+i] = (i % 5 == 0);
                m[i]    = (i % 3 == 0);
                m[128+6*i +: 6] = 6'((i * 7 + 3) % 64);
            end else begin
                m[64+i] = (i % 7 == 2);
                m[i]    = (i % 2 == 1);
                m[128+6*i +: 6] = 6'(63 - i);
            end
        end
        return m;
    endfunction

    // drive at negedge, result is sampled at the next negedge
    task automatic one_req(input string req, input logic [AW-1:0] ea, input logic [6:0] el,
                           input logic [1:0] ek);
        req_valid = 1'b1;
        @(negedge clk);
        check(req, rsp_addr, rsp_len, rsp_kind, rsp_valid, ea, el, ek, 1'b1);
    endtask

    initial begin
        #(5 * 190000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: got hang, exp completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [AW-1:0] pb;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", rsp_addr, rsp_len, rsp_kind, rsp_valid, '0, '0, '0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", rsp_addr, rsp_len, rsp_kind, rsp_valid, '0, '0, '0, 1'b0);

        // R2: uncompressed page, other fields scrambled
        pb = 40'h12_3456_7000;
        page_base = pb;
        pte_comp = 1'b0;
        for (int i = 0; i < 64; i++) begin
            line_idx = 6'(i);
            pte_type = 3'(i);
            pte_size = 2'(i);
            pte_base_off = 3'(i + 1);
            meta = make_meta(i % 2);
            one_req("R2 raw page", pb + AW'(i * 64), 7'd64, 2'b11);
        end

        // R3 R4 R5 R6 R7 R8: compressed sweep
        pte_comp = 1'b1;
        for (int p = 0; p < 2; p++) begin
            meta = make_meta(p);
            for (int c = 0; c < 4; c++) begin
                int offs, eoff, mask;
                offs = (c == 0) ? 5 : (c == 1) ? 3 : (c == 2) ? 7 : 6;
                mask = (1 << c) - 1;
                eoff = offs & ~mask & 7;
                pte_size = 2'(c);
                pte_base_off = 3'(offs);
                for (int t = 0; t < 8; t++) begin
                    int s;
                    logic [AW-1:0] fr;
                    s = (t >= 4) ? 64 : (8 << t);
                    pte_type = 3'(t);
                    pb = AW'(40'h80_0000_0000 + p * 40'h1_0000 + t * 40'h1000);
                    page_base = pb;
                    fr = pb + AW'(eoff * 512);
                    for (int i = 0; i < 64; i++) begin
                        line_idx = 6'(i);
                        if (meta[64+i]) begin
                            one_req("R7 zero line", fr + AW'(i * s), 7'd0, 2'b00);
                        end else if (meta[i]) begin
                            int k;
                            k = int'(meta[128+6*i +: 6]);
                            one_req("R8 exception slot R6", fr + AW'(64 * s + 64 + 64 * k), 7'd64, 2'b10);
                        end else begin
                            one_req("R5 compressed line R3 R4", fr + AW'(i * s), 7'(s), 2'b01);
                        end
                    end
                end
            end
        end

        // R1: response drops after the last request
        req_valid = 1'b0;
        @(negedge clk);
        check("R1 drop", rsp_addr, rsp_len, rsp_kind, rsp_valid, '0, '0, '0, 1'b0);
        // R1: isolated request after a gap
        @(negedge clk);
        pte_comp = 1'b0;
        page_base = 40'h0;
        line_idx = 6'd63;
        one_req("R1 gap then R2", AW'(63 * 64), 7'd64, 2'b11);
        req_valid = 1'b0;
        @(negedge clk);
        check("R1 single", rsp_addr, rsp_len, rsp_kind, rsp_valid, '0, '0, '0, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule